// File: doc/BRIEF.md
# Flash Command and Interrupt Register Front-End

This block is the register face of a NAND-style flash controller. A host reads and writes 16-bit registers over a simple single-cycle port. The registers are eight start-address words, a start-buffer word, a command word, two configuration words, a controller status word and an interrupt status word. A write to the command register is decoded at once. Commands that need the array launch one of three engines (load, program, erase) with a one-cycle start pulse. The front-end then waits for that engine's done strobe and its error flag, and folds the result into the interrupt and error bits.

Commands that only bookkeep (lock and unlock variants, verify-read, secure-area entry, erase resume) resolve on the write edge. The two reset opcodes restore the warm-reset register image. An interrupt line follows the master interrupt flag, and one configuration bit selects its polarity. The host acknowledges by AND-writing the interrupt register. Once the master flag is gone, the error bits clear themselves, and only then are new commands accepted.

Top module: `flash_cmd_frontend`

## Requirements
- R1: Word addresses are as follows: 0x00 to 0x07 start address 0 to 7, 0x08 start buffer, 0x09 command, 0x0A configuration-1, 0x0B configuration-2, 0x0C controller status (read-only), 0x0D interrupt status, 0x0E write-protect status (read-only, always 0x0002). Start addresses and configuration-2 read back what was written. Reads are combinational.
- R2: After the asynchronous cold reset, the registers read as follows: interrupt status 0x8080, configuration-1 0x40C0, configuration-2 0x0000, controller status 0x0000, start buffer 0x0000, start addresses 0, command 0.
- R3: A warm reset, from a one-cycle `warmRst` pulse or an accepted opcode 0x00F0 or 0x00F3, restores the R2 image on that clock edge. The one difference is that interrupt status becomes 0x8010. A pending engine command is abandoned.
- R4: A write to interrupt status replaces it with the old value AND the written value. If bit 15 of that result is 0, controller status bits 10 to 13 are cleared in the same edge.
- R5: A command write while interrupt status bit 15 is 1 is ignored. No engine starts, and the command and interrupt registers keep their values.
- R6: `intOut` equals interrupt status bit 15 when configuration-1 bit 6 is 1, and the inverse of bit 15 when it is 0.
- R7: A start-buffer write keeps bits 11:8 as buffer select and bits 1:0 as sector count, where 0 means 4. A read returns the buffer select in bits 11:8, and in bit 1 the value of bit 1 of (count minus 1). All other bits read 0.
- R8: Configuration-1 reads return the stored word with bits 4:0 forced to 0.
- R9: Load opcodes 0x0000 and 0x0013 raise `engStart[0]` for exactly the one cycle after the write edge. On the engine's done they set interrupt bits 15 and 7. If the engine reports an error, they also set status bits 10 and 13.
- R10: Program opcodes 0x0080, 0x001A and 0x001B use `engStart[1]`. On done they set interrupt bits 15 and 6, plus status bits 10 and 12 on error.
- R11: Erase opcodes 0x0094 and 0x0095 use `engStart[2]`. On done they set interrupt bits 15 and 5, plus status bits 10 and 11 on error.
- R12: Opcodes 0x0023, 0x0027, 0x002A, 0x002C, 0x0065 and 0x0071 set only interrupt bit 15. Opcode 0x0030 sets bits 15 and 5. Opcode 0x00B0 changes only the command register. All take effect on the write edge.
- R13: Any other command value sets interrupt bit 15 and status bit 10 on the write edge.
- R14: While an engine command is pending, command writes are ignored. An `engDone` with no command pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warmRst | input | 1 | Synchronous warm reset request, one cycle |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` |
| intOut | output | 1 | Interrupt line with configurable polarity |
| engStart | output | 3 | One-cycle start pulse: bit 0 load, bit 1 program, bit 2 erase |
| engDone | input | 1 | Engine completion strobe |
| engErr | input | 1 | Engine failure flag, valid with `engDone` |
| bufSel | output | 4 | Buffer select from the start-buffer register |
| secCount | output | 3 | Sector count 1 to 4 |
| startAddrs | output | 128 | All start-address words, word 0 in the low bits |

## Verification
Register writes take effect on the clock edge that samples `regWe`. Reads are combinational, so the bench writes on a falling edge and reads back one nanosecond after the following falling edge. An engine start pulse is registered on the accepting edge and is checked in the low phase right after it. It is checked again one cycle later to show that it has dropped. Engine completion bits appear on the edge that samples `engDone`, and the bench reads them back in the low phase after that edge. The interrupt pin is combinational from the registers and is sampled at the same points.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

  localparam int DATA_W  = 16;
  localparam int NUM_ENG = 3;

  // engine slots on engStart
  localparam int ENG_LOAD  = 0;
  localparam int ENG_PROG  = 1;
  localparam int ENG_ERASE = 2;

  // interrupt status bit positions
  localparam int INT_MASTER = 15;
  localparam int INT_LOAD   = 7;
  localparam int INT_PROG   = 6;
  localparam int INT_ERASE  = 5;

  // controller status bit positions
  localparam int ERR_CMD   = 10;
  localparam int ERR_ERASE = 11;
  localparam int ERR_PROG  = 12;
  localparam int ERR_LOAD  = 13;

  localparam int CFG1_POL = 6;

  // register word addresses (start addresses sit at 0..7)
  localparam int A_BUF  = 8;
  localparam int A_CMD  = 9;
  localparam int A_CFG1 = 10;
  localparam int A_CFG2 = 11;
  localparam int A_STAT = 12;
  localparam int A_INT  = 13;
  localparam int A_WP   = 14;

  localparam logic [DATA_W-1:0] CFG1_INIT = 16'h40C0;
  localparam logic [DATA_W-1:0] INT_COLD  = 16'h8080;
  localparam logic [DATA_W-1:0] INT_WARM  = 16'h8010;
  localparam logic [DATA_W-1:0] WP_VALUE  = 16'h0002;
  localparam logic [DATA_W-1:0] CFG1_RMASK = 16'hFFE0;

  typedef enum logic [2:0] {
    OPK_LOAD, OPK_PROG, OPK_ERASE, OPK_MASTER,
    OPK_RESUME, OPK_NOP, OPK_RESET, OPK_BAD
  } opKind_e;

  typedef struct packed {
    logic latchCmd;
    logic warmReset;
    logic setMaster;
    logic setLoad;
    logic setProg;
    logic setErase;
    logic errCmd;
    logic errLoad;
    logic errProg;
    logic errErase;
  } strobe_t;

  function automatic opKind_e decodeOp(input logic [DATA_W-1:0] op);
    case (op)
      16'h0000, 16'h0013:                   decodeOp = OPK_LOAD;
      16'h0080, 16'h001A, 16'h001B:         decodeOp = OPK_PROG;
      16'h0094, 16'h0095:                   decodeOp = OPK_ERASE;
      16'h0023, 16'h0027, 16'h002A,
      16'h002C, 16'h0065, 16'h0071:         decodeOp = OPK_MASTER;
      16'h0030:                             decodeOp = OPK_RESUME;
      16'h00B0:                             decodeOp = OPK_NOP;
      16'h00F0, 16'h00F3:                   decodeOp = OPK_RESET;
      default:                              decodeOp = OPK_BAD;
    endcase
  endfunction

endpackage

// File: rtl/fcf_ctrl.sv
module fcf_ctrl
  import fcf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               warmRst,
  input  logic               cmdWrite,
  input  logic [DATA_W-1:0]  cmdData,
  input  logic               masterFlag,
  input  logic               engDone,
  input  logic               engErr,
  output strobe_t            strb,
  output logic [NUM_ENG-1:0] engStart,
  output logic               pending
);

  logic    pendQ;
  opKind_e pendKindQ;
  opKind_e kind;
  logic    accept;
  logic    launch;
  logic [NUM_ENG-1:0] launchVec;

  assign pending = pendQ;
  assign kind    = decodeOp(cmdData);
  assign accept  = cmdWrite && !masterFlag && !pendQ;
  assign launch  = accept && !warmRst &&
                   (kind == OPK_LOAD || kind == OPK_PROG || kind == OPK_ERASE);

  always_comb begin
    launchVec = '0;
    case (kind)
      OPK_LOAD:  launchVec[ENG_LOAD]  = 1'b1;
      OPK_PROG:  launchVec[ENG_PROG]  = 1'b1;
      OPK_ERASE: launchVec[ENG_ERASE] = 1'b1;
      default:   launchVec = '0;
    endcase
  end

  always_comb begin
    strb = '0;
    if (warmRst) begin
      strb.warmReset = 1'b1;
    end else if (pendQ && engDone) begin
      strb.setMaster = 1'b1;
      strb.errCmd    = engErr;
      case (pendKindQ)
        OPK_LOAD: begin
          strb.setLoad = 1'b1;
          strb.errLoad = engErr;
        end
        OPK_PROG: begin
          strb.setProg = 1'b1;
          strb.errProg = engErr;
        end
        default: begin
          strb.setErase = 1'b1;
          strb.errErase = engErr;
        end
      endcase
    end else if (accept) begin
      strb.latchCmd = 1'b1;
      case (kind)
        OPK_MASTER: strb.setMaster = 1'b1;
        OPK_RESUME: begin
          strb.setMaster = 1'b1;
          strb.setErase  = 1'b1;
        end
        OPK_RESET:  strb.warmReset = 1'b1;
        OPK_BAD: begin
          strb.setMaster = 1'b1;
          strb.errCmd    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ     <= 1'b0;
      pendKindQ <= OPK_NOP;
      engStart  <= '0;
    end else if (warmRst) begin
      pendQ    <= 1'b0;
      engStart <= '0;
    end else begin
      engStart <= launch ? launchVec : '0;
      if (launch) begin
        pendQ     <= 1'b1;
        pendKindQ <= kind;
      end else if (pendQ && engDone) begin
        pendQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fcf_regs.sv
module fcf_regs
  import fcf_pkg::*;
#(
  parameter int NUM_START = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        regWe,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  input  strobe_t                     strb,
  output logic [DATA_W-1:0]           regRdata,
  output logic [DATA_W-1:0]           intStatQ,
  output logic [DATA_W-1:0]           ctrlStatQ,
  output logic                        intOut,
  output logic [3:0]                  bufSel,
  output logic [2:0]                  secCount,
  output logic [NUM_START*DATA_W-1:0] startAddrs
);

  localparam int SA_W = (NUM_START > 1) ? $clog2(NUM_START) : 1;
  localparam logic [DATA_W-1:0] ERR_MASK =
    (DATA_W'(1) << ERR_CMD) | (DATA_W'(1) << ERR_ERASE) |
    (DATA_W'(1) << ERR_PROG) | (DATA_W'(1) << ERR_LOAD);

  logic [NUM_START-1:0][DATA_W-1:0] startAddrQ;
  logic [DATA_W-1:0] cmdQ, cfg1Q, cfg2Q;
  logic [3:0] bufSelQ;
  logic [2:0] secCntQ;
  logic [DATA_W-1:0] intAnd, intNext, statNext, intSet, statSet;
  logic intWr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  for (genvar i = 0; i < NUM_START; i++) begin : gStart
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        startAddrQ[i] <= '0;
      else if (strb.warmReset)           startAddrQ[i] <= '0;
      else if (regWe && hit(regAddr, i)) startAddrQ[i] <= regWdata;
    end
    assign startAddrs[i*DATA_W +: DATA_W] = startAddrQ[i];
  end

  // AND-clear first, then completion bits from the same edge are merged in
  always_comb begin
    intWr   = regWe && hit(regAddr, A_INT);
    intAnd  = intWr ? (intStatQ & regWdata) : intStatQ;
    intSet  = '0;
    statSet = '0;
    intSet[INT_MASTER] = strb.setMaster;
    intSet[INT_LOAD]   = strb.setLoad;
    intSet[INT_PROG]   = strb.setProg;
    intSet[INT_ERASE]  = strb.setErase;
    statSet[ERR_CMD]   = strb.errCmd;
    statSet[ERR_LOAD]  = strb.errLoad;
    statSet[ERR_PROG]  = strb.errProg;
    statSet[ERR_ERASE] = strb.errErase;
    intNext  = intAnd | intSet;
    statNext = ((intWr && !intAnd[INT_MASTER]) ? (ctrlStatQ & ~ERR_MASK) : ctrlStatQ)
               | statSet;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ      <= '0;
      cfg1Q     <= CFG1_INIT;
      cfg2Q     <= '0;
      bufSelQ   <= '0;
      secCntQ   <= 3'd1;
      ctrlStatQ <= '0;
      intStatQ  <= INT_COLD;
    end else if (strb.warmReset) begin
      cmdQ      <= '0;
      cfg1Q     <= CFG1_INIT;
      cfg2Q     <= '0;
      bufSelQ   <= '0;
      secCntQ   <= 3'd1;
      ctrlStatQ <= '0;
      intStatQ  <= INT_WARM;
    end else begin
      if (strb.latchCmd) cmdQ <= regWdata;
      if (regWe && hit(regAddr, A_CFG1)) cfg1Q <= regWdata;
      if (regWe && hit(regAddr, A_CFG2)) cfg2Q <= regWdata;
      if (regWe && hit(regAddr, A_BUF)) begin
        bufSelQ <= regWdata[11:8];
        secCntQ <= (regWdata[1:0] == 2'd0) ? 3'd4 : {1'b0, regWdata[1:0]};
      end
      intStatQ  <= intNext;
      ctrlStatQ <= statNext;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr < ADDR_W'(NUM_START)) begin
      regRdata = startAddrQ[regAddr[SA_W-1:0]];
    end else begin
      case (regAddr)
        ADDR_W'(A_BUF): begin
          regRdata[11:8] = bufSelQ;
          regRdata[1]    = (secCntQ == 3'd3) || (secCntQ == 3'd4);
        end
        ADDR_W'(A_CMD):  regRdata = cmdQ;
        ADDR_W'(A_CFG1): regRdata = cfg1Q & CFG1_RMASK;
        ADDR_W'(A_CFG2): regRdata = cfg2Q;
        ADDR_W'(A_STAT): regRdata = ctrlStatQ;
        ADDR_W'(A_INT):  regRdata = intStatQ;
        ADDR_W'(A_WP):   regRdata = WP_VALUE;
        default:         regRdata = '0;
      endcase
    end
  end

  assign intOut   = intStatQ[INT_MASTER] ^ ~cfg1Q[CFG1_POL];
  assign bufSel   = bufSelQ;
  assign secCount = secCntQ;

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import fcf_pkg::*;
#(
  parameter int NUM_START = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        warmRst,
  input  logic                        regWe,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  output logic [DATA_W-1:0]           regRdata,
  output logic                        intOut,
  output logic [NUM_ENG-1:0]          engStart,
  input  logic                        engDone,
  input  logic                        engErr,
  output logic [3:0]                  bufSel,
  output logic [2:0]                  secCount,
  output logic [NUM_START*DATA_W-1:0] startAddrs
);

  strobe_t           strb;
  logic [DATA_W-1:0] intStatQ;
  logic [DATA_W-1:0] ctrlStatQ;
  logic              pending;
  logic              cmdWrite;

  assign cmdWrite = regWe && (regAddr == ADDR_W'(A_CMD));

  fcf_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .warmRst    (warmRst),
    .cmdWrite   (cmdWrite),
    .cmdData    (regWdata),
    .masterFlag (intStatQ[INT_MASTER]),
    .engDone    (engDone),
    .engErr     (engErr),
    .strb       (strb),
    .engStart   (engStart),
    .pending    (pending)
  );

  fcf_regs #(.NUM_START(NUM_START), .ADDR_W(ADDR_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .strb       (strb),
    .regRdata   (regRdata),
    .intStatQ   (intStatQ),
    .ctrlStatQ  (ctrlStatQ),
    .intOut     (intOut),
    .bufSel     (bufSel),
    .secCount   (secCount),
    .startAddrs (startAddrs)
  );

endmodule

// File: rtl/fcf_checker.sv
module fcf_checker
  import fcf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               warmRst,
  input logic               regWe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               wdMaster,
  input logic               engDone,
  input logic [NUM_ENG-1:0] engStart,
  input logic               pending,
  input logic [DATA_W-1:0]  intStat,
  input logic [3:0]         errBits
);

  // R5: a command write seen while the master flag is up never launches an engine
  assert_cmd_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == ADDR_W'(A_CMD) && intStat[INT_MASTER] && !pending)
      |=> (engStart == '0));

  // R9: at most one engine is started at a time
  assert_start_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(engStart));

  // R9: a start pulse lasts a single cycle
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (engStart != '0) |=> (engStart == '0));

  // R4: acknowledging with bit 15 low leaves no error flag behind
  assert_err_autoclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == ADDR_W'(A_INT) && !wdMaster && !warmRst &&
     !(pending && engDone)) |=> (errBits == 4'b0000));

  // R3: warm reset pin gives the warm interrupt image
  assert_warm_image_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warmRst |=> (intStat == INT_WARM));

  // R14: an engine completion while pending raises the master flag
  assert_done_master_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && engDone && !warmRst) |=> intStat[INT_MASTER]);

endmodule

bind flash_cmd_frontend fcf_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .warmRst  (warmRst),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .wdMaster (regWdata[15]),
  .engDone  (engDone),
  .engStart (engStart),
  .pending  (pending),
  .intStat  (intStatQ),
  .errBits  (ctrlStatQ[13:10])
);

// File: tb/flash_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_frontend_tb_top;

  localparam int AW = 5;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warmRst = 1'b0;
  logic regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic intOut;
  logic [2:0] engStart;
  logic engDone = 1'b0;
  logic engErr = 1'b0;
  logic [3:0] bufSel;
  logic [2:0] secCount;
  logic [NS*16-1:0] startAddrs;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_frontend #(.NUM_START(NS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .warmRst(warmRst), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .intOut(intOut), .engStart(engStart), .engDone(engDone), .engErr(engErr),
    .bufSel(bufSel), .secCount(secCount), .startAddrs(startAddrs)
  );

  localparam int RA_BUF = 8, RA_CMD = 9, RA_CFG1 = 10, RA_CFG2 = 11;
  localparam int RA_STAT = 12, RA_INT = 13, RA_WP = 14;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = AW'(a); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    regAddr = AW'(a);
    #1;
    d = regRdata;
  endtask

  task automatic done(input logic e);
    @(negedge clk);
    engDone = 1'b1; engErr = e;
    @(negedge clk);
    engDone = 1'b0; engErr = 1'b0;
  endtask

  // 0 load, 1 prog, 2 erase, 3 master-only, 4 resume, 5 no-op, 6 reset, 7 unknown
  function automatic int opClass(input logic [15:0] op);
    if (op == 16'h0000 || op == 16'h0013) return 0;
    if (op == 16'h0080 || op == 16'h001A || op == 16'h001B) return 1;
    if (op == 16'h0094 || op == 16'h0095) return 2;
    if (op == 16'h0023 || op == 16'h0027 || op == 16'h002A || op == 16'h002C ||
        op == 16'h0065 || op == 16'h0071) return 3;
    if (op == 16'h0030) return 4;
    if (op == 16'h00B0) return 5;
    if (op == 16'h00F0 || op == 16'h00F3) return 6;
    return 7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nVec++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] expInt, expStat;
    logic errToggle;
    int cls;
    string tg;
    errToggle = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 cold image
    rd(RA_INT, v);  check("R2 int", v, 16'h8080);
    rd(RA_CFG1, v); check("R2 cfg1", v, 16'h40C0);
    rd(RA_CFG2, v); check("R2 cfg2", v, 16'h0000);
    rd(RA_STAT, v); check("R2 stat", v, 16'h0000);
    rd(RA_BUF, v);  check("R2 buf", v, 16'h0000);
    rd(RA_CMD, v);  check("R2 cmd", v, 16'h0000);
    rd(3, v);       check("R2 start3", v, 16'h0000);
    rd(RA_WP, v);   check("R1 wp", v, 16'h0002);
    check("R6 intOut cold", {15'd0, intOut}, 16'h0001);

    // R5: master set after cold reset, load refused
    wr(RA_CMD, 16'h0000);
    check("R5 no start", {13'd0, engStart}, 16'h0000);
    rd(RA_INT, v); check("R5 int kept", v, 16'h8080);

    // R1 start addresses and cfg2
    for (int i = 0; i < NS; i++) wr(i, 16'h1111 * 16'(i) + 16'h0003);
    wr(RA_CFG2, 16'hA5A5);
    for (int i = 0; i < NS; i++) begin
      rd(i, v); check("R1 start", v, 16'h1111 * 16'(i) + 16'h0003);
    end
    rd(RA_CFG2, v); check("R1 cfg2", v, 16'hA5A5);

    // R7 start buffer sweep
    for (int s = 0; s < 64; s++) begin
      int cnt;
      logic [15:0] e;
      cnt = ((s & 3) == 0) ? 4 : (s & 3);
      wr(RA_BUF, 16'hF0FC | 16'((s >> 2) << 8) | 16'(s & 3));
      e = 16'((s >> 2) << 8) | (((cnt - 1) & 2) != 0 ? 16'h0002 : 16'h0000);
      rd(RA_BUF, v); check("R7 buf", v, e);
      check("R7 count out", {13'd0, secCount}, 16'(cnt));
    end

    // R8 cfg1 mask, R6 polarity
    wr(RA_CFG1, 16'hFFFF);
    rd(RA_CFG1, v); check("R8 cfg1", v, 16'hFFE0);
    check("R6 active-high master", {15'd0, intOut}, 16'h0001);
    wr(RA_CFG1, 16'hFFBF);
    check("R6 inverted master", {15'd0, intOut}, 16'h0000);
    wr(RA_INT, 16'h0000);
    check("R6 inverted idle", {15'd0, intOut}, 16'h0001);
    wr(RA_CFG1, 16'h40C0);
    check("R6 active-high idle", {15'd0, intOut}, 16'h0000);

    // R4 AND semantics and error auto-clear, via unknown opcode (R13)
    wr(RA_CMD, 16'h0100);
    rd(RA_INT, v);  check("R13 int", v, 16'h8000);
    rd(RA_STAT, v); check("R13 stat", v, 16'h0400);
    wr(RA_INT, 16'h80FF);
    rd(RA_INT, v);  check("R4 and keep", v, 16'h8000);
    rd(RA_STAT, v); check("R4 err kept", v, 16'h0400);
    wr(RA_CMD, 16'h0080);
    check("R5 refused start", {13'd0, engStart}, 16'h0000);
    rd(RA_CMD, v); check("R5 cmd kept", v, 16'h0100);
    wr(RA_INT, 16'h7FFF);
    rd(RA_INT, v);  check("R4 cleared", v, 16'h0000);
    rd(RA_STAT, v); check("R4 err cleared", v, 16'h0000);

    // R14 pending behaviour and stray done
    done(1'b1);
    rd(RA_INT, v);  check("R14 stray done int", v, 16'h0000);
    rd(RA_STAT, v); check("R14 stray done stat", v, 16'h0000);
    wr(RA_CMD, 16'h0080);
    check("R10 start", {13'd0, engStart}, 16'h0002);
    wr(RA_CMD, 16'h0094);
    check("R14 no second start", {13'd0, engStart}, 16'h0000);
    rd(RA_CMD, v); check("R14 cmd kept", v, 16'h0080);
    done(1'b0);
    rd(RA_INT, v); check("R14 done int", v, 16'h8040);

    // R3 warm reset pin
    wr(2, 16'hBEEF);
    wr(RA_CFG2, 16'h1234);
    wr(RA_BUF, 16'h0A03);
    @(negedge clk); warmRst = 1'b1;
    @(negedge clk); warmRst = 1'b0;
    rd(RA_INT, v);  check("R3 int", v, 16'h8010);
    rd(2, v);       check("R3 start", v, 16'h0000);
    rd(RA_CFG2, v); check("R3 cfg2", v, 16'h0000);
    rd(RA_BUF, v);  check("R3 buf", v, 16'h0000);
    rd(RA_CMD, v);  check("R3 cmd", v, 16'h0000);

    // opcode sweep R9..R13, R3 (reset opcodes)
    for (int op = 0; op < 256; op++) begin
      wr(RA_INT, 16'h0000);
      cls = opClass(16'(op));
      wr(RA_CMD, 16'(op));
      expStat = 16'h0000;
      if (cls <= 2) begin
        tg = (cls == 0) ? "R9" : (cls == 1) ? "R10" : "R11";
        check({tg, " start"}, {13'd0, engStart}, 16'(1 << cls));
        @(negedge clk);
        check({tg, " pulse end"}, {13'd0, engStart}, 16'h0000);
        done(errToggle);
        expInt = 16'h8000 | ((cls == 0) ? 16'h0080 : (cls == 1) ? 16'h0040 : 16'h0020);
        if (errToggle)
          expStat = 16'h0400 | ((cls == 0) ? 16'h2000 : (cls == 1) ? 16'h1000 : 16'h0800);
        errToggle = ~errToggle;
      end else begin
        tg = (cls == 6) ? "R3" : (cls == 7) ? "R13" : "R12";
        check({tg, " no start"}, {13'd0, engStart}, 16'h0000);
        case (cls)
          3: expInt = 16'h8000;
          4: expInt = 16'h8020;
          5: expInt = 16'h0000;
          6: expInt = 16'h8010;
          default: begin expInt = 16'h8000; expStat = 16'h0400; end
        endcase
      end
      rd(RA_INT, v);  check({tg, " int"}, v, expInt);
      rd(RA_STAT, v); check({tg, " stat"}, v, expStat);
      rd(RA_CMD, v);  check({tg, " cmd"}, v, (cls == 6) ? 16'h0000 : 16'(op));
      check("R6 pin", {15'd0, intOut}, {15'd0, expInt[15]});
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule